// File: doc/BRIEF.md
# Processor Bus Memory Target with Burst Stepping and Time-Out Monitor

This block answers memory cycles on a synchronous 32-bit processor bus with big-endian bit numbering. A master raises a start strobe for one clock together with the address, the direction and a size code. If the address falls inside the target's window, the target waits a fixed number of clocks and then raises an acknowledge for one clock, carrying read data or taking write data. Behind it sits a small word array that is cleared at reset.

A burst moves four 32-bit words. The master keeps the word-index address bits still for the whole burst, so the target steps them itself. The index wraps inside the 16-byte line, and a burst that starts mid-line still touches all four words of that line. A bus monitor runs beside the target. It restarts its count at each accepted start and at each acknowledge. If the count expires, it raises an error acknowledge for one clock, which ends the cycle with no data taken.

Bus bit 0 is the most significant bit. On the ports, bus data line D0 is `wdata[31]`/`rdata[31]` and address bit A31 is `addr[0]`. The sequencer's states are IDLE, WAIT, ACK and MISS. Its transitions are: IDLE to WAIT on a decoded start when wait states are configured, IDLE to ACK on a decoded start when there are none, IDLE to MISS on a start outside the window, WAIT to ACK when the wait count runs out, ACK to WAIT (or ACK) for the next burst beat, ACK to IDLE after the last beat, and any state to IDLE on an error acknowledge.

Top module: `pbus_target`

## Requirements
- R1: After reset, `ta` and `tea` are low, `rdata` is zero and every stored word reads as zero.
- R2: If `ts` is high in cycle 0 with an address in the window, `ta` is high in cycle WAIT_STATES+1 for exactly one clock. Successive burst beats follow at a spacing of WAIT_STATES+1 cycles.
- R3: Size code `tsiz`=00 (and 11) is a 32-bit transfer. All 32 data lines carry data and `addr[1:0]` is ignored. `rdata` is zero in every cycle except the acknowledge cycle of a read.
- R4: Size code 10 is a 16-bit transfer on `wdata[31:16]`/`rdata[31:16]`. `addr[1]`=0 selects word bits 31:16 and `addr[1]`=1 selects bits 15:0. `addr[0]` is ignored, the other half of the word keeps its value, and `rdata[15:0]` reads as zero.
- R5: Size code 01 is an 8-bit transfer on `wdata[31:24]`/`rdata[31:24]`. `addr[1:0]`=k selects word bits 31-8k down to 24-8k, the other three bytes are unchanged, and `rdata[23:0]` reads as zero.
- R6: With `burst`=1, a read returns four whole words. They start at word index `addr[3:2]` and step by one modulo four inside the line chosen by the higher address bits. `tsiz` and `addr[1:0]` are ignored.
- R7: A burst write stores the `wdata` value present in each beat's acknowledge cycle into that beat's word, in the same wrapping order as R6.
- R8: A start whose `addr` bits above the array do not equal BASE_ADDR gets no `ta`. `tea` is high for one clock in cycle TIMEOUT after the start, and the cycle ends with the array unchanged.
- R9: A `ts` sampled while a cycle is in progress is ignored. It produces no acknowledge and does not change the array.
- R10: An acknowledge in the last cycle before the monitor would expire cancels the error. Each acknowledge restarts the count, so a decoded burst with TIMEOUT = WAIT_STATES+2 never sees `tea`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampling |
| rst_n | input | 1 | Active-low synchronous reset |
| ts | input | 1 | Start strobe, one clock per cycle |
| addr | input | 32 | Byte address; `addr[0]` is bus bit A31 |
| rd_wr | input | 1 | 1 = read, 0 = write |
| tsiz | input | 2 | Size code: 00 word, 01 byte, 10 half, 11 word |
| burst | input | 1 | 1 = four-beat word burst |
| wdata | input | 32 | Write data; `wdata[31]` is bus line D0 |
| ta | output | 1 | Transfer acknowledge, one clock per beat |
| tea | output | 1 | Error acknowledge from the time-out monitor |
| rdata | output | 32 | Read data, valid with `ta` on reads |

## Verification
The acknowledge of a beat and the monitor's expiry can fall in the same cycle. The bench builds the target with TIMEOUT set to WAIT_STATES+2, so every decoded acknowledge lands in exactly the cycle where an unanswered count would trip. Decoded single transfers and four-beat bursts are run under this setting. The scoreboard records every `ta` and `tea` with its cycle number, and any `tea` on a decoded cycle is an unexpected item and fails. Undecoded addresses are also run, and there the same counter must fire in cycle TIMEOUT.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK,
        ST_MISS
    } pbt_state_e;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;

endpackage

// File: rtl/pbt_lanes.sv
module pbt_lanes
    import pbt_pkg::*;
(
    input  logic [1:0]  size_i,
    input  logic [1:0]  offs_i,
    input  logic [31:0] stored_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic [31:0] merged_o
);

    logic [4:0]  sh;
    logic [31:0] lane_mask;

    always_comb begin
        sh          = 5'd0;
        lane_mask   = 32'hFFFF_FFFF;
        bus_rdata_o = stored_i;
        merged_o    = bus_wdata_i;
        unique case (size_i)
            SZ_BYTE: begin
                sh          = 5'((2'd3 - offs_i) * 8);
                lane_mask   = 32'h0000_00FF << sh;
                bus_rdata_o = ((stored_i >> sh) & 32'h0000_00FF) << 24;
                merged_o    = (stored_i & ~lane_mask)
                            | ({24'd0, bus_wdata_i[31:24]} << sh);
            end
            SZ_HALF: begin
                sh          = offs_i[1] ? 5'd0 : 5'd16;
                lane_mask   = 32'h0000_FFFF << sh;
                bus_rdata_o = ((stored_i >> sh) & 32'h0000_FFFF) << 16;
                merged_o    = (stored_i & ~lane_mask)
                            | ({16'd0, bus_wdata_i[31:16]} << sh);
            end
            default: begin
                bus_rdata_o = stored_i;
                merged_o    = bus_wdata_i;
            end
        endcase
    end

endmodule

// File: rtl/pbt_store.sv
module pbt_store #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                cells[i] <= '0;
            end
        end else if (we_i) begin
            cells[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[idx_i];

endmodule

// File: rtl/pbt_busmon.sv
module pbt_busmon #(
    parameter int TIMEOUT = 16,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ts_i,
    input  logic burst_i,
    input  logic ta_i,
    output logic tea_o
);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       beats_left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            cnt        <= '0;
            beats_left <= 2'd0;
            tea_o      <= 1'b0;
        end else begin
            tea_o <= 1'b0;
            if (!active) begin
                if (ts_i && !tea_o) begin
                    active     <= 1'b1;
                    cnt        <= CNT_W'(1);
                    beats_left <= burst_i ? 2'd3 : 2'd0;
                end
            end else if (ta_i) begin
                cnt <= CNT_W'(1);
                if (beats_left == 2'd0) begin
                    active <= 1'b0;
                end else begin
                    beats_left <= beats_left - 2'd1;
                end
            end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
                tea_o  <= 1'b1;
                active <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pbus_target.sv
module pbus_target
    import pbt_pkg::*;
#(
    parameter int          WAIT_STATES = 2,
    parameter int          TIMEOUT     = 16,
    parameter int          MEM_WORDS   = 16,
    parameter logic [31:0] BASE_ADDR   = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ts,
    input  logic [31:0] addr,
    input  logic        rd_wr,
    input  logic [1:0]  tsiz,
    input  logic        burst,
    input  logic [31:0] wdata,
    output logic        ta,
    output logic        tea,
    output logic [31:0] rdata
);

    localparam int IDX_W  = $clog2(MEM_WORDS);
    localparam int LINE_W = IDX_W - 2;
    localparam int WCNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

    pbt_state_e         state;
    logic [WCNT_W-1:0]  wcnt;
    logic [LINE_W-1:0]  line_q;
    logic [1:0]         word_q;
    logic [1:0]         beat_q;
    logic               burst_q;
    logic               rd_q;
    logic [1:0]         size_q;
    logic [1:0]         offs_q;
    logic               hit;

    logic [31:0]        stored;
    logic [31:0]        steered;
    logic [31:0]        merged;
    logic               mem_we;

    assign hit = (addr[31:IDX_W+2] == BASE_ADDR[31:IDX_W+2]);

    // State register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wcnt    <= '0;
            line_q  <= '0;
            word_q  <= 2'd0;
            beat_q  <= 2'd0;
            burst_q <= 1'b0;
            rd_q    <= 1'b0;
            size_q  <= SZ_WORD;
            offs_q  <= 2'd0;
        end else if (tea) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ts) begin
                        line_q  <= addr[IDX_W+1:4];
                        word_q  <= addr[3:2];
                        offs_q  <= addr[1:0];
                        beat_q  <= 2'd0;
                        burst_q <= burst;
                        rd_q    <= rd_wr;
                        size_q  <= burst ? SZ_WORD : tsiz;
                        wcnt    <= WCNT_W'(WAIT_STATES);
                        if (!hit) begin
                            state <= ST_MISS;
                        end else if (WAIT_STATES == 0) begin
                            state <= ST_ACK;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (wcnt <= WCNT_W'(1)) begin
                        state <= ST_ACK;
                    end else begin
                        wcnt <= wcnt - WCNT_W'(1);
                    end
                end
                ST_ACK: begin
                    if (burst_q && beat_q != 2'd3) begin
                        beat_q <= beat_q + 2'd1;
                        word_q <= word_q + 2'd1;
                        wcnt   <= WCNT_W'(WAIT_STATES);
                        state  <= (WAIT_STATES == 0) ? ST_ACK : ST_WAIT;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_MISS: begin
                    state <= ST_MISS;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        ta     = (state == ST_ACK);
        mem_we = (state == ST_ACK) && !rd_q;
        rdata  = ((state == ST_ACK) && rd_q) ? steered : 32'd0;
    end

    pbt_store #(
        .WORDS  (MEM_WORDS),
        .DATA_W (32)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .idx_i   ({line_q, word_q}),
        .wdata_i (merged),
        .rdata_o (stored)
    );

    pbt_lanes u_lanes (
        .size_i      (size_q),
        .offs_i      (offs_q),
        .stored_i    (stored),
        .bus_wdata_i (wdata),
        .bus_rdata_o (steered),
        .merged_o    (merged)
    );

    pbt_busmon #(
        .TIMEOUT (TIMEOUT)
    ) u_busmon (
        .clk     (clk),
        .rst_n   (rst_n),
        .ts_i    (ts && state == ST_IDLE),
        .burst_i (burst),
        .ta_i    (ta),
        .tea_o   (tea)
    );

endmodule

// File: rtl/pbus_target_chk.sv
module pbus_target_chk #(
    parameter int WAIT_STATES = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ta,
    input logic        tea,
    input logic [31:0] rdata
);

    // R8: an error acknowledge never coincides with a data acknowledge
    a_r8_no_ta_with_tea: assert property (@(posedge clk) disable iff (!rst_n)
        !(ta && tea));

    // R8: the error acknowledge lasts one clock
    a_r8_tea_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        tea |=> !tea);

    // R8: an aborted cycle is not followed by an acknowledge
    a_r8_no_ta_after_tea: assert property (@(posedge clk) disable iff (!rst_n)
        tea |=> !ta);

    // R10: an acknowledge restarts the monitor, so no error follows it at once
    a_r10_no_tea_after_ta: assert property (@(posedge clk) disable iff (!rst_n)
        ta |=> !tea);

    // R3: read lanes stay quiet without an acknowledge
    a_r3_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ta |-> (rdata == 32'd0));

    if (WAIT_STATES > 0) begin : g_waits
        // R2: with wait states every acknowledge is a single clock
        a_r2_ta_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
            ta |=> !ta);
    end

endmodule

bind pbus_target pbus_target_chk #(
    .WAIT_STATES (WAIT_STATES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ta    (ta),
    .tea   (tea),
    .rdata (rdata)
);

// File: tb/pbus_target_bench.sv
module pbus_target_bench;

    localparam int          W    = 3;
    localparam int          T    = 5;
    localparam logic [31:0] BASE = 32'h4000_0000;

    typedef struct {
        int          cyc;
        logic        err;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts = 1'b0;
    logic [31:0] addr = '0;
    logic        rd_wr = 1'b0;
    logic [1:0]  tsiz = 2'b00;
    logic        burst = 1'b0;
    logic [31:0] wdata = '0;
    logic        ta;
    logic        tea;
    logic [31:0] rdata;

    int          cyc = 0;
    int          checks = 0;
    int          failures = 0;
    exp_t        expq[$];
    logic [31:0] model [16];
    logic [31:0] bw [4];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pbus_target #(
        .WAIT_STATES (W),
        .TIMEOUT     (T),
        .MEM_WORDS   (16),
        .BASE_ADDR   (BASE)
    ) u_pbus_target (
        .clk   (clk),
        .rst_n (rst_n),
        .ts    (ts),
        .addr  (addr),
        .rd_wr (rd_wr),
        .tsiz  (tsiz),
        .burst (burst),
        .wdata (wdata),
        .ta    (ta),
        .tea   (tea),
        .rdata (rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare every acknowledge or error acknowledge
    always @(negedge clk) begin
        if (rst_n && (ta || tea)) begin
            if (expq.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R8/R9/R10 unexpected ta=%b tea=%b at cycle %0d actual=%h expected=none",
                         ta, tea, cyc, rdata);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " R2 cycle"}, 32'(cyc), 32'(e.cyc));
                check({e.tag, " R8 kind"}, {31'd0, tea}, {31'd0, e.err});
                check({e.tag, " data"}, rdata, e.data);
            end
        end
    end

    function automatic logic hit_of(input logic [31:0] a);
        return a[31:6] == BASE[31:6];
    endfunction

    // Driver: issue one cycle, push its expected results, then wait it out
    task automatic xfer(input logic rd, input logic [31:0] a, input logic [1:0] sz,
                        input logic bst, input logic poke, input string tag);
        int   s;
        int   last;
        int   nb;
        @(negedge clk);
        ts = 1'b1; addr = a; rd_wr = rd; tsiz = sz; burst = bst; wdata = bw[0];
        s  = cyc + 1;
        nb = bst ? 4 : 1;
        if (!hit_of(a)) begin
            expq.push_back('{s + T - 1, 1'b1, 32'd0, tag});
            last = s + T - 1;
        end else begin
            for (int i = 0; i < nb; i++) begin
                logic [3:0]  idx;
                logic [31:0] ed;
                logic [1:0]  k;
                idx = {a[5:4], 2'(a[3:2] + 2'(i))};
                k   = a[1:0];
                ed  = 32'd0;
                if (rd) begin
                    if (bst || sz == 2'b00 || sz == 2'b11) ed = model[idx];
                    else if (sz == 2'b01) ed = {model[idx][31 - 8*k -: 8], 24'd0};
                    else ed = {model[idx][31 - 16*k[1] -: 16], 16'd0};
                end else begin
                    if (bst || sz == 2'b00 || sz == 2'b11) model[idx] = bw[i];
                    else if (sz == 2'b01) model[idx][31 - 8*k -: 8] = bw[i][31:24];
                    else model[idx][31 - 16*k[1] -: 16] = bw[i][31:16];
                end
                expq.push_back('{s + W + i*(W + 1), 1'b0, ed, tag});
            end
            last = s + W + (nb - 1)*(W + 1);
        end
        @(negedge clk);
        if (poke) begin
            ts = 1'b1; addr = BASE + 32'h20; rd_wr = 1'b0; tsiz = 2'b00; burst = 1'b0;
            wdata = 32'hDEAD_BEEF;
            @(negedge clk);
        end
        ts = 1'b0;
        if (hit_of(a)) begin
            for (int i = 0; i < nb; i++) begin
                while (cyc < s + W + i*(W + 1)) @(negedge clk);
                wdata = bw[i];
            end
        end
        while (cyc <= last) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 32'd0;
        for (int i = 0; i < 4; i++) bw[i] = 32'd0;
        repeat (3) @(negedge clk);
        // R1: idle outputs during and after reset
        check("R1 ta", {31'd0, ta}, 32'd0);
        check("R1 tea", {31'd0, tea}, 32'd0);
        check("R1 rdata", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        xfer(1'b1, BASE + 32'h08, 2'b00, 1'b0, 1'b0, "R1 cleared word");

        // R3: word write with low address bits set, read back at another offset
        bw[0] = 32'h1122_3344;
        xfer(1'b0, BASE + 32'h03, 2'b00, 1'b0, 1'b0, "R3 word write");
        xfer(1'b1, BASE + 32'h01, 2'b00, 1'b0, 1'b0, "R3 word read");
        xfer(1'b1, BASE + 32'h02, 2'b11, 1'b0, 1'b0, "R3 size 11 read");

        // R5: four byte writes into word 1, then word and byte reads
        for (int k = 0; k < 4; k++) begin
            bw[0] = {8'(8'hA0 + k), 24'hFF_FFFF};
            xfer(1'b0, BASE + 32'h04 + 32'(k), 2'b01, 1'b0, 1'b0, "R5 byte write");
        end
        xfer(1'b1, BASE + 32'h04, 2'b00, 1'b0, 1'b0, "R5 word after bytes");
        xfer(1'b1, BASE + 32'h06, 2'b01, 1'b0, 1'b0, "R5 byte read k2");
        bw[0] = 32'h5A00_0000;
        xfer(1'b0, BASE + 32'h01, 2'b01, 1'b0, 1'b0, "R5 byte into word 0");
        xfer(1'b1, BASE + 32'h00, 2'b00, 1'b0, 1'b0, "R5 other bytes kept");

        // R4: half writes, upper and lower, then reads
        bw[0] = 32'hBEEF_1234;
        xfer(1'b0, BASE + 32'h0B, 2'b10, 1'b0, 1'b0, "R4 low half write");
        bw[0] = 32'hCAFE_5678;
        xfer(1'b0, BASE + 32'h09, 2'b10, 1'b0, 1'b0, "R4 high half write");
        xfer(1'b1, BASE + 32'h08, 2'b00, 1'b0, 1'b0, "R4 word after halves");
        xfer(1'b1, BASE + 32'h0A, 2'b10, 1'b0, 1'b0, "R4 half read low");

        // R7, R10: burst write from word index 2 of line 1 (tsiz ignored)
        bw[0] = 32'h0000_0006; bw[1] = 32'h0000_0007;
        bw[2] = 32'h0000_0004; bw[3] = 32'h0000_0005;
        xfer(1'b0, BASE + 32'h18, 2'b01, 1'b1, 1'b0, "R7 R10 burst write");
        for (int i = 0; i < 4; i++) bw[i] = 32'd0;
        // R6, R10: burst read from word index 1 with low bits set
        xfer(1'b1, BASE + 32'h17, 2'b10, 1'b1, 1'b0, "R6 R10 burst read");
        xfer(1'b1, BASE + 32'h1C, 2'b00, 1'b0, 1'b0, "R7 word 7 single");

        // R8: undecoded read and write, then prove the array is unchanged
        xfer(1'b1, 32'h1000_0000, 2'b00, 1'b0, 1'b0, "R8 miss read");
        bw[0] = 32'hFFFF_FFFF;
        xfer(1'b0, 32'h4000_0100, 2'b00, 1'b0, 1'b0, "R8 miss write");
        xfer(1'b1, BASE + 32'h00, 2'b00, 1'b0, 1'b0, "R8 word 0 after miss");

        // R9: start strobe during a busy cycle is ignored
        bw[0] = 32'h7777_0001;
        xfer(1'b0, BASE + 32'h24, 2'b00, 1'b0, 1'b1, "R9 write with poke");
        xfer(1'b1, BASE + 32'h20, 2'b00, 1'b0, 1'b0, "R9 poked word unchanged");
        xfer(1'b1, BASE + 32'h24, 2'b00, 1'b0, 1'b1, "R9 read with poke");

        repeat (8) @(negedge clk);
        check("R8 R9 R10 all expected items seen", 32'(expq.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule